// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the sequence of 32-bit-word addresses for one DMA channel that moves a rectangular region of memory. A start pulse captures a word-aligned base address, a row length, a row pitch, a row count and two attribute bits. The block then presents one address per handshake to a data mover through a valid/ready pair. Every programmed length and the base address are counted in words, so the base is the byte address divided by four.

With a non-zero row length the block walks each row, jumps to the next pitch boundary and reports completion with a single pulse after the last row. With a row length of zero it becomes a circular-buffer sweeper. It walks pitch × (rows) words, returns to the base and repeats until stopped. It raises an event at the end of each of the two equal halves of that region. A stop input abandons any transfer at once.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset the block is idle: `busy`, `addrValid`, `doneEvt` and `halfEvt` are all low.
- R2: A `start` pulse while idle captures every `cfg*` input. In the following cycle `busy` and `addrValid` are high and `addrOut` equals `cfgAddr`. Later changes to the `cfg*` inputs, and any `start` pulse while busy, have no effect on the running sequence.
- R3: `addrOut` changes only in a cycle where `addrValid` and `addrReady` are both high. While `addrReady` is low, `addrOut` and `addrValid` hold.
- R4: When `cfgXlen` is non-zero, each row consists of `cfgXlen` consecutive word addresses, rising by one per handshake.
- R5: Each new row starts at the previous row's first address plus `cfgWidth`. The first address of row r is `cfgAddr + r*cfgWidth`.
- R6: `cfgYlen` holds the row count minus one, so 0 means a single row. In the cycle after the handshake on the last word of the last row, `doneEvt` is high for exactly one cycle, `busy` and `addrValid` are low, and the block is idle again.
- R7: When `cfgXlen` is 0, the addresses run `cfgAddr` to `cfgAddr + T - 1`, where T = `cfgWidth*(cfgYlen+1)` and T ≥ 2. They then restart at `cfgAddr` indefinitely, and `doneEvt` never rises.
- R8: In circular mode, `halfEvt` is high for one cycle in the cycle after the handshake on position floor(T/2)-1 (the end of half A). It is also high in the cycle after the handshake on position T-1 (the end of half B). It is low otherwise and never high together with `doneEvt`.
- R9: `dirOut` shows the captured `cfgDir` (1 = memory to device, 0 = device to memory). `burstOut` shows the captured `cfgBurst` (1 = 4-word bursts, 0 = single words) for the whole transfer.
- R10: `stop` while busy returns the block to idle in the next cycle without raising `doneEvt` or `halfEvt`. A handshake in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture configuration and begin (idle only) |
| stop | input | 1 | Abort the current transfer |
| cfgAddr | input | AW | Base word address |
| cfgXlen | input | LW | Words per row; 0 selects circular mode |
| cfgWidth | input | LW | Row pitch in words |
| cfgYlen | input | LW | Row count minus one |
| cfgDir | input | 1 | Direction: 1 memory to device, 0 device to memory |
| cfgBurst | input | 1 | 1 = 4-word bursts, 0 = single words |
| addrOut | output | AW | Current word address |
| addrValid | output | 1 | Address is valid |
| addrReady | input | 1 | Data mover accepts the address |
| dirOut | output | 1 | Captured direction |
| burstOut | output | 1 | Captured burst mode |
| busy | output | 1 | A transfer is in progress |
| doneEvt | output | 1 | One-cycle completion pulse (row mode) |
| halfEvt | output | 1 | One-cycle half-buffer pulse (circular mode) |

## Verification
A wrong column or row counter shows up at once as a skipped or repeated address. A pitch error shows on the first address of a row, which is checked against base plus row times pitch in the cycle after the row's last handshake. An off-by-one in the end or half comparators moves `doneEvt` or `halfEvt` by one cycle away from the handshake that should cause it, or moves the first wrapped address; the bench compares these against positions it computes itself. Stall cycles show whether a counter advances without a handshake, and the mismatch appears in the very next sampled cycle.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROWS = 2'd1,
    ST_RING = 2'd2
  } seqState_t;

  // Strobes from the control FSM into the address datapath.
  typedef struct packed {
    logic load;     // capture configuration, point at base
    logic step;     // advance one word
    logic newLine;  // jump to the next row boundary
    logic wrap;     // return to base in circular mode
  } ctrlStrb_t;

endpackage

// File: rtl/dma2d_ctrl.sv
module dma2d_ctrl
  import dma2d_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      stop,
  input  logic      loopSel,
  input  logic      addrReady,
  input  logic      lastCol,
  input  logic      lastRow,
  input  logic      atHalf,
  input  logic      atEnd,
  output ctrlStrb_t strb,
  output logic      busy,
  output logic      doneEvt,
  output logic      halfEvt
);

  seqState_t state, stateNxt;
  logic fire;
  logic finish;
  logic halfHit;

  assign busy = (state != ST_IDLE);
  assign fire = busy && addrReady && !stop;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    finish   = 1'b0;
    halfHit  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          stateNxt  = loopSel ? ST_RING : ST_ROWS;
        end
      end
      ST_ROWS: begin
        if (stop) begin
          stateNxt = ST_IDLE;
        end else if (fire) begin
          if (lastCol) begin
            if (lastRow) begin
              finish   = 1'b1;
              stateNxt = ST_IDLE;
            end else begin
              strb.newLine = 1'b1;
            end
          end else begin
            strb.step = 1'b1;
          end
        end
      end
      ST_RING: begin
        if (stop) begin
          stateNxt = ST_IDLE;
        end else if (fire) begin
          halfHit = atHalf || atEnd;
          if (atEnd) strb.wrap = 1'b1;
          else       strb.step = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      doneEvt <= 1'b0;
      halfEvt <= 1'b0;
    end else begin
      state   <= stateNxt;
      doneEvt <= finish;
      halfEvt <= halfHit;
    end
  end

  // R10
  stop_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stop) |=> (!busy && !doneEvt && !halfEvt));

  // R8
  evt_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({doneEvt, halfEvt}));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneEvt |-> (!busy || $past(start)) && !$past(doneEvt));

endmodule

// File: rtl/dma2d_dpath.sv
module dma2d_dpath
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrb_t     strb,
  input  logic [AW-1:0] cfgAddr,
  input  logic [LW-1:0] cfgXlen,
  input  logic [LW-1:0] cfgWidth,
  input  logic [LW-1:0] cfgYlen,
  input  logic          cfgDir,
  input  logic          cfgBurst,
  output logic [AW-1:0] addrOut,
  output logic          dirOut,
  output logic          burstOut,
  output logic          lastCol,
  output logic          lastRow,
  output logic          atHalf,
  output logic          atEnd
);

  localparam int PW = 2 * LW;

  logic [AW-1:0] baseR;
  logic [AW-1:0] lineStart;
  logic [LW-1:0] xlenR;
  logic [LW-1:0] widthR;
  logic [LW-1:0] ylenR;
  logic [LW-1:0] colCnt;
  logic [LW-1:0] rowCnt;
  logic [PW-1:0] posCnt;
  logic [PW-1:0] totalM1;
  logic [PW-1:0] halfM1;
  logic [PW-1:0] regionIn;
  logic [AW-1:0] nextLine;

  assign regionIn = PW'(cfgWidth) * (PW'(cfgYlen) + PW'(1));
  assign nextLine = lineStart + AW'(widthR);

  assign lastCol = (colCnt == xlenR - LW'(1));
  assign lastRow = (rowCnt == ylenR);
  assign atHalf  = (posCnt == halfM1);
  assign atEnd   = (posCnt == totalM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseR     <= '0;
      lineStart <= '0;
      addrOut   <= '0;
      xlenR     <= '0;
      widthR    <= '0;
      ylenR     <= '0;
      colCnt    <= '0;
      rowCnt    <= '0;
      posCnt    <= '0;
      totalM1   <= '0;
      halfM1    <= '0;
      dirOut    <= 1'b0;
      burstOut  <= 1'b0;
    end else begin
      if (strb.load) begin
        baseR     <= cfgAddr;
        lineStart <= cfgAddr;
        addrOut   <= cfgAddr;
        xlenR     <= cfgXlen;
        widthR    <= cfgWidth;
        ylenR     <= cfgYlen;
        colCnt    <= '0;
        rowCnt    <= '0;
        posCnt    <= '0;
        totalM1   <= regionIn - PW'(1);
        halfM1    <= (regionIn >> 1) - PW'(1);
        dirOut    <= cfgDir;
        burstOut  <= cfgBurst;
      end else if (strb.newLine) begin
        lineStart <= nextLine;
        addrOut   <= nextLine;
        colCnt    <= '0;
        rowCnt    <= rowCnt + LW'(1);
      end else if (strb.wrap) begin
        addrOut <= baseR;
        colCnt  <= '0;
        posCnt  <= '0;
      end else if (strb.step) begin
        addrOut <= addrOut + AW'(1);
        colCnt  <= colCnt + LW'(1);
        posCnt  <= posCnt + PW'(1);
      end
    end
  end

  // R4
  step_incr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> (addrOut == $past(addrOut) + AW'(1)));

  // R5
  row_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    (colCnt == '0) |-> (addrOut == lineStart));

  // R7
  wrap_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrap |=> (addrOut == baseR && posCnt == '0));

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          stop,
  input  logic [AW-1:0] cfgAddr,
  input  logic [LW-1:0] cfgXlen,
  input  logic [LW-1:0] cfgWidth,
  input  logic [LW-1:0] cfgYlen,
  input  logic          cfgDir,
  input  logic          cfgBurst,
  output logic [AW-1:0] addrOut,
  output logic          addrValid,
  input  logic          addrReady,
  output logic          dirOut,
  output logic          burstOut,
  output logic          busy,
  output logic          doneEvt,
  output logic          halfEvt
);

  ctrlStrb_t strb;
  logic lastCol, lastRow, atHalf, atEnd;
  logic loopSel;

  assign loopSel   = (cfgXlen == '0);
  assign addrValid = busy;

  dma2d_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .stop     (stop),
    .loopSel  (loopSel),
    .addrReady(addrReady),
    .lastCol  (lastCol),
    .lastRow  (lastRow),
    .atHalf   (atHalf),
    .atEnd    (atEnd),
    .strb     (strb),
    .busy     (busy),
    .doneEvt  (doneEvt),
    .halfEvt  (halfEvt)
  );

  dma2d_dpath #(.AW(AW), .LW(LW)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cfgAddr (cfgAddr),
    .cfgXlen (cfgXlen),
    .cfgWidth(cfgWidth),
    .cfgYlen (cfgYlen),
    .cfgDir  (cfgDir),
    .cfgBurst(cfgBurst),
    .addrOut (addrOut),
    .dirOut  (dirOut),
    .burstOut(burstOut),
    .lastCol (lastCol),
    .lastRow (lastRow),
    .atHalf  (atHalf),
    .atEnd   (atEnd)
  );

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !addrReady && !stop) |=> (addrValid && $stable(addrOut)));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneEvt |-> !addrValid);

  // R9
  attr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && busy) |-> ($stable(dirOut) && $stable(burstOut)));

endmodule

// File: tb/test_dma2d_addr_gen.sv
module test_dma2d_addr_gen;
  localparam int AW = 32;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic          start, stop;
  logic [AW-1:0] cfgAddr;
  logic [LW-1:0] cfgXlen, cfgWidth, cfgYlen;
  logic          cfgDir, cfgBurst;
  logic [AW-1:0] addrOut;
  logic          addrValid, addrReady;
  logic          dirOut, burstOut, busy, doneEvt, halfEvt;

  int  nChk = 0;
  int  nBad = 0;
  bit  allDone = 1'b0;

  always #10 clk = ~clk;

  dma2d_addr_gen #(.AW(AW), .LW(LW)) i_dma2d_addr_gen (
    .clk(clk), .rstN(rstN), .start(start), .stop(stop),
    .cfgAddr(cfgAddr), .cfgXlen(cfgXlen), .cfgWidth(cfgWidth),
    .cfgYlen(cfgYlen), .cfgDir(cfgDir), .cfgBurst(cfgBurst),
    .addrOut(addrOut), .addrValid(addrValid), .addrReady(addrReady),
    .dirOut(dirOut), .burstOut(burstOut), .busy(busy),
    .doneEvt(doneEvt), .halfEvt(halfEvt)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  endtask

  task automatic startXfer(int base, int xlen, int width, int ylen, bit dir, bit burst);
    @(negedge clk);
    cfgAddr  = AW'(base);
    cfgXlen  = LW'(xlen);
    cfgWidth = LW'(width);
    cfgYlen  = LW'(ylen);
    cfgDir   = dir;
    cfgBurst = burst;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // scramble configuration: must not affect the running transfer (R2)
    cfgAddr  = 32'h0000_7777;
    cfgXlen  = (xlen == 0) ? 16'd5 : 16'd0;
    cfgWidth = 16'd1;
    cfgYlen  = 16'd9;
    cfgDir   = ~dir;
    cfgBurst = ~burst;
    chk("R2", "busy after start", 64'(busy), 64'd1);
    chk("R2", "first address", 64'(addrOut), 64'(base));
    chk("R9", "dirOut", 64'(dirOut), 64'(dir));
    chk("R9", "burstOut", 64'(burstOut), 64'(burst));
  endtask

  task automatic testReset();
    chk("R1", "busy", 64'(busy), 64'd0);
    chk("R1", "addrValid", 64'(addrValid), 64'd0);
    chk("R1", "doneEvt", 64'(doneEvt), 64'd0);
    chk("R1", "halfEvt", 64'(halfEvt), 64'd0);
  endtask

  task automatic runRows(int base, int xlen, int width, int ylen, bit dir, bit burst,
                         int stallEvery, bit poke);
    int k = 0;
    startXfer(base, xlen, width, ylen, dir, burst);
    for (int r = 0; r <= ylen; r++) begin
      for (int c = 0; c < xlen; c++) begin
        int expA = base + r * width + c;
        if (stallEvery != 0 && (k % stallEvery) == 0) begin
          addrReady = 1'b0;
          @(negedge clk);
          chk("R3", "address held during stall", 64'(addrOut), 64'(expA));
          chk("R3", "valid held during stall", 64'(addrValid), 64'd1);
        end
        if (c == 0) chk("R5", "row start address", 64'(addrOut), 64'(expA));
        else        chk("R4", "in-row address", 64'(addrOut), 64'(expA));
        addrReady = 1'b1;
        start = poke && (k == 1);
        @(negedge clk);
        start = 1'b0;
        k++;
        if (!(r == ylen && c == xlen - 1))
          chk("R6", "no early done", 64'(doneEvt), 64'd0);
      end
    end
    addrReady = 1'b0;
    chk("R6", "done pulse", 64'(doneEvt), 64'd1);
    chk("R6", "idle after done", 64'(addrValid), 64'd0);
    @(negedge clk);
    chk("R6", "done is one cycle", 64'(doneEvt), 64'd0);
  endtask

  task automatic runRing(int base, int width, int ylen, bit dir);
    int total = width * (ylen + 1);
    int half  = total / 2;
    startXfer(base, 0, width, ylen, dir, 1'b0);
    for (int k = 0; k < 2 * total + 2; k++) begin
      int p = k % total;
      chk("R7", "ring address", 64'(addrOut), 64'(base + p));
      addrReady = 1'b1;
      @(negedge clk);
      chk("R8", "half event", 64'(halfEvt),
          64'((p == half - 1) || (p == total - 1)));
      chk("R7", "no done in ring", 64'(doneEvt), 64'd0);
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    addrReady = 1'b0;
    chk("R10", "ring stopped", 64'(addrValid), 64'd0);
    chk("R10", "no half on stop", 64'(halfEvt), 64'd0);
    @(negedge clk);
    chk("R10", "no done after stop", 64'(doneEvt), 64'd0);
  endtask

  task automatic runAbort();
    startXfer(500, 4, 8, 3, 1'b1, 1'b0);
    for (int k = 0; k < 2; k++) begin
      addrReady = 1'b1;
      @(negedge clk);
    end
    chk("R4", "address before abort", 64'(addrOut), 64'd502);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    addrReady = 1'b0;
    chk("R10", "idle after stop", 64'(busy), 64'd0);
    chk("R10", "no done on stop", 64'(doneEvt), 64'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10", "still idle", 64'(addrValid), 64'd0);
      chk("R10", "still no done", 64'(doneEvt), 64'd0);
    end
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; stop = 1'b0; addrReady = 1'b0;
    cfgAddr = '0; cfgXlen = '0; cfgWidth = '0; cfgYlen = '0;
    cfgDir = 1'b0; cfgBurst = 1'b0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    runRows(100, 3, 5, 2, 1'b1, 1'b0, 2, 1'b0);
    runRows(40, 4, 4, 0, 1'b0, 1'b1, 0, 1'b1);
    runRows(7, 1, 20, 3, 1'b1, 1'b1, 3, 1'b0);
    runRing(2000, 4, 1, 1'b0);
    runRing(3000, 3, 2, 1'b1);
    runAbort();
    runRows(60, 2, 3, 1, 1'b0, 1'b0, 0, 1'b0);
    allDone = 1'b1;
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!allDone) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

endmodule